// File: doc/BRIEF.md
# Banked Host Window Arbiter for Display Memory

This block shares an 8 KB display memory between a host processor bus and a display refresh engine. Ownership follows the host's two-phase bus clock. While the E phase is high, the host bus owns the memory. While E is low, the refresh engine owns it. An inverted copy of E is made inside the block and used as the ownership select, so the two sides never drive the memory in the same phase.

The host sees a 1 KB window built from two 512-byte halves. Bit 9 of the window address picks which half is used. Each half has its own write-only 4-bit page register, so either half can show any of the 16 pages of 512 bytes. The memory address is the selected page number joined to window address bits 8:0. Because the two halves map independently, one linear 1 KB host write can run across two unrelated pages.

The refresh side uses a valid/ready request. The refresh engine raises `rf_valid` together with a full memory address. The request is accepted in any cycle where `rf_ready` is high, which is exactly the E-low phase. While E is high, `rf_ready` is low. During that time the engine must hold its request and keep its address stable until the next E-low phase. Read data for an accepted request appears on `rf_rdata` in the same cycle.

Top module: `dispwin_top`

## Requirements
- R1: After reset both page registers hold page 0. During E high, window offset 0x005 maps to memory address 0x0005, and window offset 0x205 also maps to 0x0005.
- R2: A page-register write takes effect from the next clock edge. A write happens at a clock edge where E is high, `pg_cs_n` is low, `host_rw` is 0 (write) and `pg_sel` is 0. It loads the low-half register with `host_wdata[3:0]`. Bits 7:4 of the data are ignored.
- R3: The same kind of write with `pg_sel` = 1 loads the high-half register from `host_wdata[3:0]`. The low-half register is left unchanged.
- R4: While E is high, `ram_addr` = {page, `host_addr[8:0]`}. The page is the low-half register when `host_addr[9]` = 0 and the high-half register when it is 1. Page n therefore starts at byte n×0x200.
- R5: While E is high, `ram_we_n` is low exactly when `win_cs_n` is low and `host_rw` = 0. In that case `ram_wdata` equals `host_wdata`.
- R6: While E is low, `ram_addr` equals `rf_addr` and `ram_we_n` stays high for any host input. `rf_ready` is high when E is low and low when E is high.
- R7: `ram_oe_n` is low in two cases: E is high with `win_cs_n` low and `host_rw` = 1, or E is low with `rf_valid` high. In every other case it is high.
- R8: `host_rdata` equals `ram_rdata` while a host window read is active, meaning E is high, `win_cs_n` low and `host_rw` = 1. Otherwise `host_rdata` is 0. `rf_rdata` always equals `ram_rdata`.
- R9: A page-register write attempt has no effect on the mapping if it happens while E is low or while `pg_cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; E and Q are sampled on its rising edge |
| rst_n | input | 1 | Active-low reset; clears both page registers |
| bus_e | input | 1 | Host bus E phase; high means the host owns the memory |
| bus_q | input | 1 | Host bus Q phase; leads E by a quarter cycle |
| host_rw | input | 1 | 1 = read, 0 = write |
| host_addr | input | 10 | Window offset; bit 9 picks the half |
| host_wdata | input | 8 | Host write data |
| win_cs_n | input | 1 | Active-low select for the memory window |
| pg_cs_n | input | 1 | Active-low select for the page registers |
| pg_sel | input | 1 | Page register target: 0 = low half, 1 = high half |
| host_rdata | output | 8 | Window read data, 0 when no host read is active |
| rf_valid | input | 1 | Refresh read request |
| rf_ready | output | 1 | Refresh request accepted this cycle (E low) |
| rf_addr | input | 13 | Refresh memory address |
| rf_rdata | output | 8 | Refresh read data |
| ram_addr | output | 13 | Memory address |
| ram_wdata | output | 8 | Memory write data |
| ram_we_n | output | 1 | Memory write enable, active low |
| ram_oe_n | output | 1 | Memory output enable, active low |
| ram_rdata | input | 8 | Memory read data |

## Verification
The assertions assume that E and Q form a proper quadrature pair: E rises only while Q is high and falls only while Q is low. They also assume that the host's inputs change only between clock edges. The bench produces E and Q from a four-step phase counter (00, 01, 11, 10), so every E edge meets this rule. It never toggles E directly. Random host, page-register and refresh inputs are applied on the falling clock edge and held through the next rising edge. Directed cases first wait for the phase they need.

// File: rtl/dispwin_pkg.sv
package dispwin_pkg;
  localparam int PAGE_W = 4;
  localparam int OFFS_W = 9;
  localparam int DATA_W = 8;
  localparam int WIN_W  = OFFS_W + 1;
  localparam int MEM_W  = PAGE_W + OFFS_W;

  typedef enum logic {OWN_REFRESH = 1'b0, OWN_HOST = 1'b1} owner_e;
endpackage

// File: rtl/dispwin_pages.sv
module dispwin_pages
  import dispwin_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_phase,
  input  logic              pg_cs_n,
  input  logic              pg_sel,
  input  logic              host_rw,
  input  logic [DATA_W-1:0] wdata,
  output logic [PAGE_W-1:0] lo_page,
  output logic [PAGE_W-1:0] hi_page
);
  logic [1:0] wr_en;

  always_comb begin
    wr_en = 2'b00;
    if (host_phase && !pg_cs_n && !host_rw)
      wr_en[pg_sel] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_page <= '0;
      hi_page <= '0;
    end else begin
      if (wr_en[0]) lo_page <= wdata[PAGE_W-1:0];
      if (wr_en[1]) hi_page <= wdata[PAGE_W-1:0];
    end
  end

  // R2
  lo_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en[0] |=> lo_page == $past(wdata[PAGE_W-1:0]));
  // R3
  hi_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en[1] |=> hi_page == $past(wdata[PAGE_W-1:0]));
  // R9
  lo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_phase && !pg_cs_n && !host_rw && !pg_sel) |=> $stable(lo_page));
  // R9
  hi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_phase && !pg_cs_n && !host_rw && pg_sel) |=> $stable(hi_page));
endmodule

// File: rtl/dispwin_compose.sv
module dispwin_compose
  import dispwin_pkg::*;
(
  input  logic [WIN_W-1:0]  win_addr,
  input  logic [PAGE_W-1:0] lo_page,
  input  logic [PAGE_W-1:0] hi_page,
  output logic [MEM_W-1:0]  mem_addr
);
  logic [PAGE_W-1:0] page;

  always_comb begin
    page     = win_addr[OFFS_W] ? hi_page : lo_page;
    mem_addr = {page, win_addr[OFFS_W-1:0]};
  end
endmodule

// File: rtl/dispwin_mux.sv
module dispwin_mux
  import dispwin_pkg::*;
(
  input  logic              inv_e,
  input  logic              win_cs_n,
  input  logic              host_rw,
  input  logic [MEM_W-1:0]  host_mem_addr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              rf_valid,
  input  logic [MEM_W-1:0]  rf_addr,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic [MEM_W-1:0]  ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  output logic              ram_we_n,
  output logic              ram_oe_n,
  output logic [DATA_W-1:0] host_rdata,
  output logic              rf_ready,
  output logic [DATA_W-1:0] rf_rdata
);
  owner_e owner;
  logic   host_rd, host_wr;

  always_comb begin
    owner    = inv_e ? OWN_REFRESH : OWN_HOST;
    host_rd  = (owner == OWN_HOST) && !win_cs_n && host_rw;
    host_wr  = (owner == OWN_HOST) && !win_cs_n && !host_rw;
    rf_ready = (owner == OWN_REFRESH);
    if (owner == OWN_HOST) begin
      ram_addr  = host_mem_addr;
      ram_wdata = host_wdata;
      ram_oe_n  = !host_rd;
    end else begin
      ram_addr  = rf_addr;
      ram_wdata = '0;
      ram_oe_n  = !rf_valid;
    end
    ram_we_n   = !host_wr;
    host_rdata = host_rd ? ram_rdata : '0;
    rf_rdata   = ram_rdata;
  end
endmodule

// File: rtl/dispwin_top.sv
module dispwin_top
  import dispwin_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_e,
  input  logic              bus_q,
  input  logic              host_rw,
  input  logic [WIN_W-1:0]  host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              win_cs_n,
  input  logic              pg_cs_n,
  input  logic              pg_sel,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              rf_valid,
  output logic              rf_ready,
  input  logic [MEM_W-1:0]  rf_addr,
  output logic [DATA_W-1:0] rf_rdata,
  output logic [MEM_W-1:0]  ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  output logic              ram_we_n,
  output logic              ram_oe_n,
  input  logic [DATA_W-1:0] ram_rdata
);
  logic              inv_e;
  logic [PAGE_W-1:0] lo_page, hi_page;
  logic [MEM_W-1:0]  host_mem_addr;

  assign inv_e = ~bus_e;

  dispwin_pages u_pages (
    .clk(clk), .rst_n(rst_n), .host_phase(~inv_e), .pg_cs_n(pg_cs_n),
    .pg_sel(pg_sel), .host_rw(host_rw), .wdata(host_wdata),
    .lo_page(lo_page), .hi_page(hi_page)
  );

  dispwin_compose u_compose (
    .win_addr(host_addr), .lo_page(lo_page), .hi_page(hi_page),
    .mem_addr(host_mem_addr)
  );

  dispwin_mux u_mux (
    .inv_e(inv_e), .win_cs_n(win_cs_n), .host_rw(host_rw),
    .host_mem_addr(host_mem_addr), .host_wdata(host_wdata),
    .rf_valid(rf_valid), .rf_addr(rf_addr), .ram_rdata(ram_rdata),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_we_n(ram_we_n),
    .ram_oe_n(ram_oe_n), .host_rdata(host_rdata), .rf_ready(rf_ready),
    .rf_rdata(rf_rdata)
  );

  // input rule: E rises only while Q is high
  e_rise_q_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_e) |-> bus_q);
  // input rule: E falls only while Q is low
  e_fall_q_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_e) |-> !bus_q);
  // R6
  rf_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_e |-> (ram_we_n && ram_addr == rf_addr && rf_ready));
  // R6
  host_blocks_rf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_e |-> !rf_ready);
  // R5
  host_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_we_n |-> (bus_e && !win_cs_n && !host_rw && ram_wdata == host_wdata));
  // R4
  host_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_e |-> ram_addr[OFFS_W-1:0] == host_addr[OFFS_W-1:0]);
  // R7
  no_dual_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ram_we_n && !ram_oe_n));
endmodule

// File: tb/dispwin_top_tb.sv
module dispwin_top_tb;
  logic        clk = 0, rst_n = 0;
  logic        bus_e = 0, bus_q = 0, host_rw = 1, win_cs_n = 1, pg_cs_n = 1, pg_sel = 0;
  logic [9:0]  host_addr = '0;
  logic [7:0]  host_wdata = '0, ram_rdata = '0;
  logic        rf_valid = 0;
  logic [12:0] rf_addr = '0;
  logic [7:0]  host_rdata, rf_rdata, ram_wdata;
  logic        rf_ready, ram_we_n, ram_oe_n;
  logic [12:0] ram_addr;

  int n_tests = 0, n_fail = 0, ph = 0;
  logic [3:0] m_lo = 0, m_hi = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dispwin_top u_dut (.*);

  function automatic logic [12:0] exp_addr();
    if (!bus_e) return rf_addr;
    return {host_addr[9] ? m_hi : m_lo, host_addr[8:0]};
  endfunction
  function automatic logic exp_we_n();
    return !(bus_e && !win_cs_n && !host_rw);
  endfunction
  function automatic logic exp_oe_n();
    return bus_e ? !(!win_cs_n && host_rw) : !rf_valid;
  endfunction
  function automatic logic [7:0] exp_hrd();
    return (bus_e && !win_cs_n && host_rw) ? ram_rdata : 8'h00;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_all(string req);
    chk({req, " addr"}, ram_addr, exp_addr());
    chk({"R5 we ", req}, ram_we_n, exp_we_n());
    chk({"R7 oe ", req}, ram_oe_n, exp_oe_n());
    chk({"R8 hrd ", req}, host_rdata, exp_hrd());
    chk({"R8 rfrd ", req}, rf_rdata, ram_rdata);
    chk({"R6 ready ", req}, rf_ready, !bus_e);
    if (!ram_we_n) chk({"R5 wdata ", req}, ram_wdata, host_wdata);
  endtask

  // one clock: commit model at rising edge, advance phase at falling edge
  task automatic tick();
    @(posedge clk);
    if (bus_e && !pg_cs_n && !host_rw) begin
      if (pg_sel) m_hi = host_wdata[3:0]; else m_lo = host_wdata[3:0];
    end
    @(negedge clk);
    ph = (ph + 1) % 4;
    bus_e = (ph >= 2);
    bus_q = (ph == 1 || ph == 2);
    pg_cs_n = 1; win_cs_n = 1; host_rw = 1;
    #1;
  endtask

  task automatic wait_e(logic v);
    do tick(); while (bus_e !== v);
  endtask

  task automatic pg_write(logic sel, logic [7:0] d);
    wait_e(1);
    pg_cs_n = 0; host_rw = 0; pg_sel = sel; host_wdata = d;
    tick();
  endtask

  task automatic host_peek(logic [9:0] a, string req, logic [12:0] exp);
    wait_e(1);
    win_cs_n = 0; host_rw = 1; host_addr = a; ram_rdata = 8'h5A;
    #1;
    chk(req, ram_addr, exp);
    check_all(req);
    tick();
  endtask

  initial begin
    #50000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset mapping
    host_peek(10'h005, "R1 low", 13'h0005);
    host_peek(10'h205, "R1 high", 13'h0005);
    // R2 low page, upper data bits ignored
    pg_write(0, 8'hF3);
    host_peek(10'h010, "R2", {4'h3, 9'h010});
    host_peek(10'h210, "R3 untouched", {4'h0, 9'h010});
    // R3 high page, low untouched
    pg_write(1, 8'h0C);
    host_peek(10'h3FF, "R3", {4'hC, 9'h1FF});
    host_peek(10'h1FF, "R4 boundary", {4'h3, 9'h1FF});
    host_peek(10'h200, "R4 boundary hi", {4'hC, 9'h000});
    // R9 write in E low ignored
    wait_e(0);
    pg_cs_n = 0; host_rw = 0; pg_sel = 0; host_wdata = 8'h07;
    #1;
    chk("R6 we in E low", ram_we_n, 1'b1);
    tick();
    host_peek(10'h001, "R9 E low", {4'h3, 9'h001});
    // R9 pg_cs_n high ignored
    wait_e(1);
    pg_cs_n = 1; host_rw = 0; pg_sel = 1; host_wdata = 8'h09;
    tick();
    host_peek(10'h201, "R9 cs high", {4'hC, 9'h001});
    // R5 host window write, R6 refresh phase
    wait_e(1);
    win_cs_n = 0; host_rw = 0; host_addr = 10'h2AB; host_wdata = 8'hC3;
    #1;
    chk("R5 we", ram_we_n, 1'b0);
    chk("R5 wdata", ram_wdata, 8'hC3);
    chk("R4 write addr", ram_addr, {4'hC, 9'h0AB});
    tick();
    wait_e(0);
    rf_valid = 1; rf_addr = 13'h1ABC; win_cs_n = 0; host_rw = 0; ram_rdata = 8'h33;
    #1;
    chk("R6 addr", ram_addr, 13'h1ABC);
    chk("R6 we", ram_we_n, 1'b1);
    chk("R7 oe", ram_oe_n, 1'b0);
    chk("R8 rf", rf_rdata, 8'h33);
    chk("R8 host zero", host_rdata, 8'h00);
    tick();
    // random mix
    for (int i = 0; i < 600; i++) begin
      host_rw    = $urandom_range(0, 1);
      win_cs_n   = $urandom_range(0, 1);
      pg_cs_n    = ($urandom_range(0, 3) != 0);
      pg_sel     = $urandom_range(0, 1);
      host_addr  = 10'($urandom);
      host_wdata = 8'($urandom);
      rf_valid   = $urandom_range(0, 1);
      rf_addr    = 13'($urandom);
      ram_rdata  = 8'($urandom);
      #1;
      check_all(bus_e ? "R4" : "R6");
      @(posedge clk);
      if (bus_e && !pg_cs_n && !host_rw) begin
        if (pg_sel) m_hi = host_wdata[3:0]; else m_lo = host_wdata[3:0];
      end
      @(negedge clk);
      ph = (ph + 1) % 4;
      bus_e = (ph >= 2);
      bus_q = (ph == 1 || ph == 2);
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule